// File: doc/BRIEF.md
# Multi-Channel PWM Match Generator

This block is a register-programmed pulse-width timer. A prescale counter divides the clock. Each prescaled tick advances a timer counter. Seven match channels compare their values against the timer counter. Each match channel has its own set of actions: it can raise an interrupt flag, restart the count, or halt the count. Match channel 0 normally sets the period by restarting the count. Channels 1 to 6 each drive one output pin. A channel runs single-edge, where it rises at the restart and falls at its own match. Channels 2 to 6 can instead run dual-edge, where they rise at the match of the channel below and fall at their own match.

Software reaches the block through a word-wide write port with an address, and reads through a combinational read port. When the PWM mode bit is clear, match writes take effect at once. When the PWM mode bit is set, match writes land in a shadow copy. A shadow value moves into the active compare value only at the next match-triggered restart, and only if that channel's latch bit is set. The latch bit then clears itself.

A small state machine governs the count. It has three states. STOPPED holds the count. RUNNING advances it. CLEARING forces the timer counter and the prescale counter to zero. The transitions are:
- STOPPED to RUNNING when the enable bit is set.
- RUNNING to STOPPED when the enable bit is cleared, or when a stop-on-match fires.
- Any state to CLEARING while the counter-reset bit is set.
- CLEARING to RUNNING or to STOPPED when the counter-reset bit is released, depending on the enable bit.

Top module: `pwmt_top`

Register word addresses:

| Address | Register |
|---|---|
| 0 | interrupt flags |
| 1 | control |
| 2 | timer counter |
| 3 | prescale limit |
| 4 | prescale counter |
| 5 | match actions |
| 6 | output config |
| 7 | latch enable |
| 8+n | match channel n |

## Requirements
- R1: After reset, the timer counter reads 0, the flag register reads 0, irq is low and all six pins are low.
- R2: While running, the timer counter advances by exactly one every P+1 clocks, where P is the prescale limit (address 3).
- R3: The match-action register (address 5) holds bit 3n as interrupt-on-match, bit 3n+1 as restart-on-match and bit 3n+2 as stop-on-match for channel n. With restart enabled on channel 0, the counter counts 0 to M0 and then returns to 0.
- R4: A stop-on-match holds the timer counter at the matched value and clears control bit 0 (enable).
- R5: A match with its interrupt bit set raises a flag and irq. The flag positions are: channels 0 to 3 at bits 0 to 3, and channels 4 to 6 at bits 8 to 10. A match whose interrupt bit is clear raises no flag.
- R6: Writing 1 to a flag bit clears it. A match event in the same cycle wins over the clear.
- R7: While control bit 1 (counter reset) is set, the timer counter and the prescale counter read 0.
- R8: A single-edge channel n (output config bit n clear) is high while the counter value is at or below Mn, and low otherwise.
- R9: A dual-edge channel n (output config bit n set, n from 2 to 6) goes high after match n-1 and low after match n. It is low throughout when the two values are equal.
- R10: A single-edge channel whose match value exceeds the period value stays high.
- R11: With PWM mode on (control bit 3), a match write has no effect on the output until latch bit n (address 7) is set and a restart occurs. The latch bit then reads 0.
- R12: A pin is driven only when PWM mode is on and its enable bit (output config bit 8+n) is set. Otherwise the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | AW | register word address |
| reg_wdata | input | DW | write data |
| reg_rdata | output | DW | read data for reg_addr |
| irq | output | 1 | high while any flag is set |
| pwm_out | output | NCH-1 | pins for channels 1 to NCH-1 |

## Verification
Random periods, prescale limits, duty values and edge-mode mixes give the main output check. Each pin is compared against the timer counter value read in the same cycle. This separates a wrong rise point from a wrong fall point, and it separates single-edge from dual-edge decoding, including the wrapped dual-edge case. Directed passes cover the remaining cases:
- a match value above the period and a disabled pin;
- a shadowed write before and after its latch bit is set;
- a flag clear timed in every phase of a four-tick period, which shows whether an event beats a simultaneous clear.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } cnt_state_t;

    localparam int A_FLAG = 0;
    localparam int A_CTL  = 1;
    localparam int A_TC   = 2;
    localparam int A_PR   = 3;
    localparam int A_PC   = 4;
    localparam int A_MCR  = 5;
    localparam int A_PCR  = 6;
    localparam int A_LER  = 7;
    localparam int A_MR0  = 8;

    // flag bit for match channel n: low four sit at the bottom, rest skip a nibble
    function automatic int flag_pos(input int n);
        return (n < 4) ? n : n + 4;
    endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] pc,
    output logic          tick
);

    assign tick = run && (pc == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (clear || tick) begin
            pc <= '0;
        end else if (run) begin
            pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/pwmt_match_bank.sv
module pwmt_match_bank #(
    parameter int DW  = 32,
    parameter int NCH = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          wr_sel,
    input  logic [DW-1:0]           wdata,
    input  logic                    shadow_mode,
    input  logic                    load,
    input  logic [NCH-1:0]          latch_en,
    input  logic                    tick,
    input  logic [DW-1:0]           tc,
    output logic [NCH-1:0][DW-1:0]  shd,
    output logic [NCH-1:0]          hit
);

    logic [NCH-1:0][DW-1:0] act;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd[g] <= '0;
                act[g] <= '0;
            end else begin
                if (wr_sel[g]) begin
                    shd[g] <= wdata;
                end
                if (wr_sel[g] && !shadow_mode) begin
                    act[g] <= wdata;
                end else if (load && latch_en[g]) begin
                    act[g] <= shd[g];
                end
            end
        end

        assign hit[g] = tick && (tc == act[g]);
    end

endmodule

// File: rtl/pwmt_edge_gen.sv
module pwmt_edge_gen #(
    parameter int NCH = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic           restart,
    input  logic [NCH-1:0] dual,
    output logic [NCH-1:0] lvl
);

    assign lvl[0] = 1'b0;

    for (genvar g = 1; g < NCH; g++) begin : g_out
        if (g == 1) begin : g_single_only
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       lvl[g] <= 1'b0;
                else if (restart) lvl[g] <= 1'b1;
                else if (hit[g])  lvl[g] <= 1'b0;
            end
        end else begin : g_either
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl[g] <= 1'b0;
                end else if (dual[g]) begin
                    if (hit[g])          lvl[g] <= 1'b0;
                    else if (hit[g-1])   lvl[g] <= 1'b1;
                end else begin
                    if (restart)         lvl[g] <= 1'b1;
                    else if (hit[g])     lvl[g] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
    import pwmt_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 7,
    parameter int AW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic [NCH-2:0] pwm_out
);

    localparam int FW = flag_pos(NCH - 1) + 1;
    localparam int MW = 3 * NCH;
    localparam logic [NCH-1:0] DUAL_OK = {{(NCH-2){1'b1}}, 2'b00};
    localparam logic [NCH-1:0] ENA_OK  = {{(NCH-1){1'b1}}, 1'b0};

    cnt_state_t st_q, st_d;
    logic run, clear;

    logic          ctl_en_q, ctl_rst_q, ctl_pwm_q;
    logic [DW-1:0] pr_q, pc, tc_q;
    logic [MW-1:0] mcr_q;
    logic [NCH-1:0] dual_q, ena_q, ler_q;
    logic [FW-1:0] flag_q, flag_set, flag_clr;

    logic tick;
    logic [NCH-1:0] hit, rst_en, stop_en, int_en, evt, wr_sel, lvl;
    logic [NCH-1:0][DW-1:0] shd;
    logic rst_hit, stop_hit, restart;

    function automatic logic wr_at(input int a);
        return reg_we && (reg_addr == AW'(a));
    endfunction

    // match action decode
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            int_en[n]  = mcr_q[3*n];
            rst_en[n]  = mcr_q[3*n+1];
            stop_en[n] = mcr_q[3*n+2];
            wr_sel[n]  = wr_at(A_MR0 + n);
        end
    end

    assign evt      = hit & int_en;
    assign rst_hit  = |(hit & rst_en);
    assign stop_hit = |(hit & stop_en);
    assign restart  = rst_hit || clear;

    // counter state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOP: begin
                if (ctl_rst_q)     st_d = ST_CLEAR;
                else if (ctl_en_q) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctl_rst_q)                    st_d = ST_CLEAR;
                else if (stop_hit || !ctl_en_q)   st_d = ST_STOP;
            end
            ST_CLEAR: begin
                if (!ctl_rst_q) st_d = ctl_en_q ? ST_RUN : ST_STOP;
            end
            default: st_d = ST_STOP;
        endcase
    end

    // state outputs
    always_comb begin
        run   = 1'b0;
        clear = 1'b0;
        unique case (st_q)
            ST_RUN:   run   = 1'b1;
            ST_CLEAR: clear = 1'b1;
            default: ;
        endcase
    end

    // timer counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             tc_q <= '0;
        else if (clear)         tc_q <= '0;
        else if (tick) begin
            if (rst_hit)        tc_q <= '0;
            else if (!stop_hit) tc_q <= tc_q + 1'b1;
        end
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en_q  <= 1'b0;
            ctl_rst_q <= 1'b0;
            ctl_pwm_q <= 1'b0;
            pr_q      <= '0;
            mcr_q     <= '0;
            dual_q    <= '0;
            ena_q     <= '0;
            ler_q     <= '0;
        end else begin
            if (wr_at(A_CTL)) begin
                ctl_en_q  <= reg_wdata[0];
                ctl_rst_q <= reg_wdata[1];
                ctl_pwm_q <= reg_wdata[3];
            end
            if (stop_hit) ctl_en_q <= 1'b0;
            if (wr_at(A_PR))  pr_q  <= reg_wdata;
            if (wr_at(A_MCR)) mcr_q <= reg_wdata[MW-1:0];
            if (wr_at(A_PCR)) begin
                dual_q <= reg_wdata[NCH-1:0] & DUAL_OK;
                ena_q  <= reg_wdata[8 +: NCH] & ENA_OK;
            end
            if (rst_hit)      ler_q <= '0;
            if (wr_at(A_LER)) ler_q <= reg_wdata[NCH-1:0];
        end
    end

    // interrupt flags, event beats clear
    always_comb begin
        flag_set = '0;
        for (int n = 0; n < NCH; n++) flag_set[flag_pos(n)] = evt[n];
        flag_clr = wr_at(A_FLAG) ? reg_wdata[FW-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    assign irq     = |flag_q;
    assign pwm_out = lvl[NCH-1:1] & ena_q[NCH-1:1] & {(NCH-1){ctl_pwm_q}};

    pwmt_prescaler #(.DW(DW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (clear),
        .limit (pr_q),
        .pc    (pc),
        .tick  (tick)
    );

    pwmt_match_bank #(.DW(DW), .NCH(NCH)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel      (wr_sel),
        .wdata       (reg_wdata),
        .shadow_mode (ctl_pwm_q),
        .load        (rst_hit),
        .latch_en    (ler_q),
        .tick        (tick),
        .tc          (tc_q),
        .shd         (shd),
        .hit         (hit)
    );

    pwmt_edge_gen #(.NCH(NCH)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .restart (restart),
        .dual    (dual_q),
        .lvl     (lvl)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(A_FLAG): reg_rdata = DW'(flag_q);
            AW'(A_CTL):  reg_rdata = DW'({ctl_pwm_q, 1'b0, ctl_rst_q, ctl_en_q});
            AW'(A_TC):   reg_rdata = tc_q;
            AW'(A_PR):   reg_rdata = pr_q;
            AW'(A_PC):   reg_rdata = pc;
            AW'(A_MCR):  reg_rdata = DW'(mcr_q);
            AW'(A_PCR):  reg_rdata = DW'({ena_q, 8'h00}) | DW'(dual_q);
            AW'(A_LER):  reg_rdata = DW'(ler_q);
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (reg_addr == AW'(A_MR0 + n)) reg_rdata = shd[n];
                end
            end
        endcase
    end

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
    parameter int DW  = 32,
    parameter int NCH = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clear,
    input logic [DW-1:0]  tc,
    input logic           rst_hit,
    input logic           stop_hit,
    input logic           ctl_en,
    input logic [NCH-1:0] evt,
    input logic           irq,
    input logic [NCH-1:0] lvl
);

    // R7
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tc == '0));

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit |=> (tc == '0));

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hit && !rst_hit) |=> (!ctl_en && tc == $past(tc)));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc != $past(tc)) |-> ((tc == $past(tc) + 1'b1) || (tc == '0)));

    // R6
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> irq);

    // R8
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit |=> lvl[1]);

endmodule

bind pwmt_top pwmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .tc       (tc_q),
    .rst_hit  (rst_hit),
    .stop_hit (stop_hit),
    .ctl_en   (ctl_en_q),
    .evt      (evt),
    .irq      (irq),
    .lvl      (lvl)
);

// File: tb/test_pwmt_top.sv
module test_pwmt_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic irq;
    logic [5:0] pwm_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int mr [7];
    int m0_b;
    logic [6:0] dual_b, ena_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwmt_top i_pwmt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    function automatic bit exp_pin(input int n, input int t);
        int a, b;
        if (!ena_b[n]) return 1'b0;
        if (n >= 2 && dual_b[n]) begin
            a = mr[n-1]; b = mr[n];
            if (a <= b) return (t > a) && (t <= b);
            return (t > a) || (t <= b);
        end
        return t <= mr[n];
    endfunction

    task automatic wave_check(input int ncyc);
        logic [DW-1:0] t;
        string req;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            rd(2, t);
            for (int n = 1; n < 7; n++) begin
                if (!ena_b[n])                    req = "R12";
                else if (n >= 2 && dual_b[n])     req = "R9";
                else if (mr[n] > m0_b)            req = "R10";
                else                              req = "R8";
                chk($sformatf("%s ch%0d tc=%0d", req, n, t), pwm_out[n-1],
                    exp_pin(n, int'(t)));
            end
        end
    endtask

    task automatic setup(input int pr);
        wr(1, 32'h2);
        wr(3, pr);
        for (int n = 0; n < 7; n++) wr(8 + n, mr[n]);
        m0_b = mr[0];
        wr(5, 32'h2);
        wr(6, {ena_b, 8'h00} | dual_b);
        wr(7, 0);
        wr(0, 32'h7FF);
        wr(1, 32'h9);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, t0, t1;
        int mx, pr, per;
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2, v); chk("R1 tc", v, 0);
        rd(0, v); chk("R1 flags", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pins", pwm_out, 0);

        // R2 prescale by 4
        wr(3, 3); wr(5, 0); wr(1, 1);
        repeat (5) @(negedge clk);
        rd(2, t0);
        repeat (16) @(negedge clk);
        rd(2, t1);
        chk("R2 tc advance", t1 - t0, 4);

        // R7 held reset
        wr(1, 3);
        repeat (3) @(negedge clk);
        rd(2, v); chk("R7 tc", v, 0);
        repeat (10) @(negedge clk);
        rd(2, v); chk("R7 tc later", v, 0);
        rd(4, v); chk("R7 pc", v, 0);

        // R3 restart on match 0
        wr(1, 2); wr(3, 0); wr(8, 5); wr(5, 32'h2); wr(1, 1);
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); rd(2, v);
            if (int'(v) > mx) mx = int'(v);
        end
        chk("R3 max tc", mx, 5);

        // R4 stop on match 2
        wr(1, 2); wr(5, 1 << 8); wr(10, 7); wr(1, 1);
        repeat (20) @(negedge clk);
        rd(2, v); chk("R4 tc held", v, 7);
        rd(1, v); chk("R4 enable cleared", v[0], 0);
        repeat (5) @(negedge clk);
        rd(2, v); chk("R4 tc still", v, 7);

        // R5 interrupt on match 4 only
        wr(1, 2); wr(0, 32'h7FF); wr(12, 3); wr(9, 2); wr(5, 1 << 12); wr(1, 1);
        repeat (10) @(negedge clk);
        rd(0, v); chk("R5 flag bit 8 only", v, 32'h100);
        chk("R5 irq", irq, 1);
        wr(1, 0);
        wr(0, 32'h100);
        @(negedge clk);
        rd(0, v); chk("R6 flag cleared", v, 0);
        chk("R6 irq low", irq, 0);

        // R6 event vs clear, period of 4 ticks
        wr(1, 2); wr(8, 3); wr(5, 32'h3); wr(1, 1);
        repeat (10) @(negedge clk);
        rd(2, t0);
        reg_we = 1'b1; reg_addr = AW'(0); reg_wdata = 32'h1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            reg_addr = AW'(0); #1;
            chk($sformatf("R6 flag after clear tc=%0d", t0), reg_rdata[0], (t0 == 3));
            reg_addr = AW'(2); #1;
            t0 = reg_rdata;
            reg_addr = AW'(0);
        end
        @(negedge clk);
        reg_we = 1'b0;

        // random patterns: R8 R9 R12
        for (int it = 0; it < 6; it++) begin
            pr = $urandom % 3;
            mr[0] = 5 + ($urandom % 8);
            for (int n = 1; n < 7; n++) mr[n] = $urandom % (mr[0] + 1);
            dual_b = 7'($urandom) & 7'h7C;
            ena_b  = (7'($urandom) & 7'h7E) | 7'h02;
            setup(pr);
            per = (mr[0] + 1) * (pr + 1);
            repeat (2 * per + 10) @(negedge clk);
            wave_check(3 * per);
        end

        // directed: R10 R11 R12
        mr = '{9, 3, 5, 14, 2, 6, 8};
        dual_b = 7'h40;
        ena_b  = 7'h5E;
        setup(0);
        repeat (30) @(negedge clk);
        wave_check(20);
        wr(9, 7);
        repeat (25) @(negedge clk);
        wave_check(20);
        rd(9, v); chk("R11 shadow readback", v, 7);
        wr(7, 32'h2);
        repeat (25) @(negedge clk);
        mr[1] = 7;
        wave_check(20);
        rd(7, v); chk("R11 latch self-clear", v, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule